// File: doc/BRIEF.md
# Register-Programmed Block Transfer Engine

This block moves data on behalf of a host processor. Software loads a small bank of 16-bit registers: source, destination, length, a mode word and a fill pattern. It then writes any value to a separate kick address. The engine copies the described range from one place in shared work RAM to another, streams a work RAM range into one of several private buffers, or fills a work RAM range with the pattern. While it works it raises `busy`.

Source and destination are coarse register values. Each becomes a byte address through a fixed left shift. Length works the same way, through its own shift. The engine copies every register it needs at the kick, so software may reprogram the bank for the next job while the current one runs. Memory beats are 16 or 32 bits wide. Each beat uses a request/grant handshake on a single master port. Read data is taken in the same cycle as the grant.

Top module: `regdma_engine`

## Requirements
- R1: The first read of a copy is at byte address `SRC << SRC_SHIFT`. Each later beat reads 2 bytes (word) or 4 bytes (dword) further on.
- R2: The first write, or buffer strobe, is at byte address `DST << DST_SHIFT`. Each later beat steps by the beat size.
- R3: A job moves `(LEN << LEN_SHIFT)` bytes, which is that amount divided by 2 (word) or by 4 (dword) beats.
- R4: The operation code is {mode[8], mode[4]}. Code 00 reads each beat from the source and then writes the read value to the destination.
- R5: Code 01 reads each beat and then raises exactly one buffer strobe for one cycle, with `buf_addr` set to the destination pointer. Channel mode[2:0]=4 selects `buf_vram_we`, channel 5 selects `buf_pal_we`, and any other channel selects `buf_aux_we`.
- R6: Code 11 issues writes only. Each beat carries the fill register. In dword mode the fill value sits in both 16-bit halves.
- R7: Code 10 is reserved. A kick with it makes no memory access or buffer strobe, and `busy` stays low.
- R8: mode[3]=0 selects word beats: `mem_wide`=0, and data uses bits 15:0 with the upper half zero. mode[3]=1 selects 32-bit beats with `mem_wide`=1.
- R9: mode[7] is stored and read back, and it does not change the data movement.
- R10: A write of any value to index 7 starts a job from the register contents at that edge. `busy` rises on the next cycle and falls in the cycle after the last beat completes. Register writes made later do not alter the running job.
- R11: A kick while `busy` is high is ignored.
- R12: A kick with a length of zero makes no access, and `busy` stays low.
- R13: Reading index 0 (source), 1 (length), 2 (destination), 3 (mode) or 4 (fill) returns the last value written, and 0 after reset. Reading index 7 returns `busy` in bit 0 and zeros in the other bits.
- R14: A memory request holds its address, direction and write data until it is granted. Pointers advance only when a beat completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_idx | input | 3 | Register index |
| cpu_wdata | input | REG_W | Register write data |
| cpu_rdata | output | REG_W | Register read data for `cpu_idx` |
| busy | output | 1 | Job in progress |
| mem_req | output | 1 | Memory request |
| mem_gnt | input | 1 | Memory grant; the beat completes on req and gnt |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_wide | output | 1 | 1 for a 32-bit beat, 0 for a 16-bit beat |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 2*REG_W | Memory write data |
| mem_rdata | input | 2*REG_W | Memory read data, valid in the grant cycle |
| buf_vram_we | output | 1 | Strobe for the video buffer |
| buf_pal_we | output | 1 | Strobe for the palette buffer |
| buf_aux_we | output | 1 | Strobe for the buffers of other channels |
| buf_addr | output | ADDR_W | Buffer byte address |
| buf_wdata | output | 2*REG_W | Buffer write data |

## Verification
The bench keeps the default 16-bit registers and 6-bit address shifts. It lowers LEN_SHIFT to 3, so that a length of 1 is only 8 bytes. With that setting a job of a few beats covers every operation code, both beat sizes and the buffer channels within a short run, and the real address scaling stays in place. Grant is driven both always-high and with a one-in-three pattern, so that held requests, and kicks arriving mid-job, occur.

// File: rtl/regdma_pkg.sv
package regdma_pkg;

  typedef enum logic [1:0] {
    OP_COPY  = 2'b00,
    OP_TOBUF = 2'b01,
    OP_RSVD  = 2'b10,
    OP_FILL  = 2'b11
  } op_e;

  localparam logic [2:0] IX_SRC  = 3'd0;
  localparam logic [2:0] IX_LEN  = 3'd1;
  localparam logic [2:0] IX_DST  = 3'd2;
  localparam logic [2:0] IX_MODE = 3'd3;
  localparam logic [2:0] IX_FILL = 3'd4;
  localparam logic [2:0] IX_KICK = 3'd7;

  typedef struct packed {
    op_e        op;
    logic       wide;
    logic [2:0] chan;
  } mode_t;

  // operation code lives in bits 8 and 4; beat size in bit 3; channel in 2:0
  function automatic mode_t decode_mode(input logic [15:0] m);
    mode_t r;
    r.op   = op_e'({m[8], m[4]});
    r.wide = m[3];
    r.chan = m[2:0];
    return r;
  endfunction

endpackage

// File: rtl/regdma_regs.sv
module regdma_regs
  import regdma_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       idx,
  input  logic [REG_W-1:0] wdata,
  input  logic             busy,
  output logic [REG_W-1:0] rdata,
  output logic [REG_W-1:0] src_q,
  output logic [REG_W-1:0] len_q,
  output logic [REG_W-1:0] dst_q,
  output logic [REG_W-1:0] fill_q,
  output mode_t            mode,
  output logic             kick
);

  localparam int NREG = 5;

  logic [REG_W-1:0] bank [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (wr_en && idx == 3'(i)) bank[i] <= wdata;
    end
  end

  assign src_q  = bank[IX_SRC];
  assign len_q  = bank[IX_LEN];
  assign dst_q  = bank[IX_DST];
  assign fill_q = bank[IX_FILL];
  assign mode   = decode_mode(16'(bank[IX_MODE]));
  assign kick   = wr_en && idx == IX_KICK;

  always_comb begin
    rdata = '0;
    if (idx < 3'(NREG))      rdata = bank[idx];
    else if (idx == IX_KICK) rdata[0] = busy;
  end

  // R13
  mode_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && idx == IX_MODE |=> bank[IX_MODE] == $past(wdata));

  // R13
  status_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx == IX_KICK |-> rdata[REG_W-1:1] == '0);

endmodule

// File: rtl/regdma_route.sv
module regdma_route #(
  parameter int VRAM_CHAN = 4,
  parameter int PAL_CHAN  = 5
) (
  input  logic       fire,
  input  logic [2:0] chan,
  output logic       vram_we,
  output logic       pal_we,
  output logic       aux_we
);

  logic hit_vram, hit_pal;

  assign hit_vram = chan == 3'(VRAM_CHAN);
  assign hit_pal  = chan == 3'(PAL_CHAN);
  assign vram_we  = fire && hit_vram;
  assign pal_we   = fire && hit_pal;
  assign aux_we   = fire && !hit_vram && !hit_pal;

endmodule

// File: rtl/regdma_seq.sv
module regdma_seq
  import regdma_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int SRC_SH = 6,
  parameter int DST_SH = 6,
  parameter int LEN_SH = 5,
  parameter int ADDR_W = 22
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                kick,
  input  logic [REG_W-1:0]    src_q,
  input  logic [REG_W-1:0]    len_q,
  input  logic [REG_W-1:0]    dst_q,
  input  logic [REG_W-1:0]    fill_q,
  input  mode_t               mode,
  input  logic                mem_gnt,
  input  logic [2*REG_W-1:0]  mem_rdata,
  output logic                busy,
  output logic                mem_req,
  output logic                mem_we,
  output logic                mem_wide,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [2*REG_W-1:0]  mem_wdata,
  output logic                buf_fire,
  output logic [2:0]          buf_chan,
  output logic [ADDR_W-1:0]   buf_addr,
  output logic [2*REG_W-1:0]  buf_data
);

  localparam int DW = 2 * REG_W;
  localparam int CW = REG_W + LEN_SH;

  function automatic logic [ADDR_W-1:0] to_byte(input logic [REG_W-1:0] v, input int sh);
    return ADDR_W'(v) << sh;
  endfunction

  function automatic logic [CW-1:0] beats_of(input logic [REG_W-1:0] len, input logic wide);
    logic [CW-1:0] nbytes;
    nbytes = CW'(len) << LEN_SH;
    return wide ? (nbytes >> 2) : (nbytes >> 1);
  endfunction

  function automatic logic [DW-1:0] fill_beat(input logic [REG_W-1:0] f, input logic wide);
    return wide ? {f, f} : {{REG_W{1'b0}}, f};
  endfunction

  function automatic logic [DW-1:0] narrow(input logic [DW-1:0] d, input logic wide);
    return wide ? d : {{REG_W{1'b0}}, d[REG_W-1:0]};
  endfunction

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_BUF} st_e;

  st_e               state;
  op_e               op_q;
  logic              wide_q;
  logic [2:0]        chan_q;
  logic [ADDR_W-1:0] sptr, dptr, step;
  logic [CW-1:0]     left, beats_now;
  logic [DW-1:0]     hold;

  // named events for the checks
  logic kick_take, start_ok, beat_done, last_beat;

  assign beats_now = beats_of(len_q, mode.wide);
  assign kick_take = kick && state == S_IDLE;
  assign start_ok  = kick_take && mode.op != OP_RSVD && beats_now != '0;
  assign beat_done = (state == S_WRITE && mem_gnt) || state == S_BUF;
  assign last_beat = beat_done && left == CW'(1);
  assign step      = wide_q ? ADDR_W'(4) : ADDR_W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= OP_COPY;
      wide_q <= 1'b0;
      chan_q <= '0;
      sptr   <= '0;
      dptr   <= '0;
      left   <= '0;
      hold   <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (start_ok) begin
            op_q   <= mode.op;
            wide_q <= mode.wide;
            chan_q <= mode.chan;
            sptr   <= to_byte(src_q, SRC_SH);
            dptr   <= to_byte(dst_q, DST_SH);
            left   <= beats_now;
            hold   <= fill_beat(fill_q, mode.wide);
            state  <= (mode.op == OP_FILL) ? S_WRITE : S_READ;
          end
        end
        S_READ: begin
          if (mem_gnt) begin
            hold  <= narrow(mem_rdata, wide_q);
            state <= (op_q == OP_TOBUF) ? S_BUF : S_WRITE;
          end
        end
        S_WRITE, S_BUF: begin
          if (beat_done) begin
            sptr <= sptr + step;
            dptr <= dptr + step;
            left <= left - CW'(1);
            if (last_beat)            state <= S_IDLE;
            else if (op_q == OP_FILL) state <= S_WRITE;
            else                      state <= S_READ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = state != S_IDLE;
  assign mem_req   = state == S_READ || state == S_WRITE;
  assign mem_we    = state == S_WRITE;
  assign mem_wide  = wide_q;
  assign mem_addr  = (state == S_READ) ? sptr : dptr;
  assign mem_wdata = hold;
  assign buf_fire  = state == S_BUF;
  assign buf_chan  = chan_q;
  assign buf_addr  = dptr;
  assign buf_data  = hold;

  // R14
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R7
  reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_take && mode.op == OP_RSVD |=> !busy);

  // R12
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_take && beats_now == '0 |=> !busy);

  // R2
  dst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done && !last_beat |=> dptr == $past(dptr) + $past(step));

  // R11
  busy_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick && busy && !beat_done |=> $stable(sptr) && $stable(dptr) && $stable(left));

  // R6
  fill_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op_q == OP_FILL |-> !(mem_req && !mem_we));

endmodule

// File: rtl/regdma_engine.sv
module regdma_engine
  import regdma_pkg::*;
#(
  parameter int REG_W     = 16,
  parameter int SRC_SHIFT = 6,
  parameter int DST_SHIFT = 6,
  parameter int LEN_SHIFT = 5,
  parameter int VRAM_CHAN = 4,
  parameter int PAL_CHAN  = 5,
  localparam int ADDR_W   = REG_W + ((SRC_SHIFT > DST_SHIFT) ? SRC_SHIFT : DST_SHIFT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_wr,
  input  logic [2:0]          cpu_idx,
  input  logic [REG_W-1:0]    cpu_wdata,
  output logic [REG_W-1:0]    cpu_rdata,
  output logic                busy,
  output logic                mem_req,
  input  logic                mem_gnt,
  output logic                mem_we,
  output logic                mem_wide,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [2*REG_W-1:0]  mem_wdata,
  input  logic [2*REG_W-1:0]  mem_rdata,
  output logic                buf_vram_we,
  output logic                buf_pal_we,
  output logic                buf_aux_we,
  output logic [ADDR_W-1:0]   buf_addr,
  output logic [2*REG_W-1:0]  buf_wdata
);

  logic [REG_W-1:0] src_q, len_q, dst_q, fill_q;
  mode_t            mode;
  logic             kick, buf_fire;
  logic [2:0]       buf_chan;

  regdma_regs #(.REG_W(REG_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cpu_wr),
    .idx    (cpu_idx),
    .wdata  (cpu_wdata),
    .busy   (busy),
    .rdata  (cpu_rdata),
    .src_q  (src_q),
    .len_q  (len_q),
    .dst_q  (dst_q),
    .fill_q (fill_q),
    .mode   (mode),
    .kick   (kick)
  );

  regdma_seq #(
    .REG_W (REG_W),
    .SRC_SH(SRC_SHIFT),
    .DST_SH(DST_SHIFT),
    .LEN_SH(LEN_SHIFT),
    .ADDR_W(ADDR_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .kick      (kick),
    .src_q     (src_q),
    .len_q     (len_q),
    .dst_q     (dst_q),
    .fill_q    (fill_q),
    .mode      (mode),
    .mem_gnt   (mem_gnt),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_wide  (mem_wide),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .buf_fire  (buf_fire),
    .buf_chan  (buf_chan),
    .buf_addr  (buf_addr),
    .buf_data  (buf_wdata)
  );

  regdma_route #(.VRAM_CHAN(VRAM_CHAN), .PAL_CHAN(PAL_CHAN)) u_route (
    .fire    (buf_fire),
    .chan    (buf_chan),
    .vram_we (buf_vram_we),
    .pal_we  (buf_pal_we),
    .aux_we  (buf_aux_we)
  );

  // R5
  buf_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buf_vram_we, buf_pal_we, buf_aux_we}) && !((buf_vram_we || buf_pal_we || buf_aux_we) && mem_req));

endmodule

// File: tb/tb_regdma_engine.sv
module tb_regdma_engine;

  localparam int LSH = 3;
  localparam int AW  = 22;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cpu_wr = 0;
  logic [2:0]  cpu_idx = 0;
  logic [15:0] cpu_wdata = 0;
  logic [15:0] cpu_rdata;
  logic        busy, mem_req, mem_we, mem_wide;
  logic        mem_gnt = 0;
  logic [AW-1:0] mem_addr, buf_addr;
  logic [31:0] mem_wdata, buf_wdata;
  logic [31:0] mem_rdata = 0;
  logic        buf_vram_we, buf_pal_we, buf_aux_we;

  always #5 clk = ~clk;

  regdma_engine #(.LEN_SHIFT(LSH)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_idx(cpu_idx),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .busy(busy),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_wide(mem_wide),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .buf_vram_we(buf_vram_we), .buf_pal_we(buf_pal_we), .buf_aux_we(buf_aux_we),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata)
  );

  // kinds: 0 read, 1 write, 2 video buffer, 3 palette buffer, 4 other buffer
  typedef struct {
    int          kind;
    int unsigned addr;
    logic [31:0] data;
    bit          wide;
  } ev_t;

  ev_t         expq[$];
  ev_t         pend[$];
  bit          arm = 0;
  bit          exp_busy = 0;
  bit          mon_on = 0;
  bit          stall_on = 0;
  int          gcnt = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  string       cur_tag = "R13";
  logic [15:0] sh [5];
  logic [7:0]  mem [int unsigned];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input int unsigned a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] rd32(input int unsigned a);
    return {mbyte(a + 3), mbyte(a + 2), mbyte(a + 1), mbyte(a)};
  endfunction

  // behavioural job model: list of expected beats built from the shadow registers
  task automatic plan_job();
    int unsigned sa, da, nbytes, step, nb, s, d;
    bit [1:0] op;
    bit wide;
    int chan;
    ev_t e;
    sa = int'(sh[0]) << 6;
    da = int'(sh[2]) << 6;
    nbytes = int'(sh[1]) << LSH;
    op = {sh[3][8], sh[3][4]};
    wide = sh[3][3];
    chan = int'(sh[3][2:0]);
    step = wide ? 4 : 2;
    nb = nbytes / step;
    if (op == 2'b10) return;
    for (int b = 0; b < int'(nb); b++) begin
      s = sa + b * step;
      d = da + b * step;
      if (op != 2'b11) begin
        e.kind = 0; e.addr = s; e.wide = wide; e.data = 0;
        pend.push_back(e);
      end
      e.addr = d; e.wide = wide;
      if (op == 2'b11) e.data = wide ? {sh[4], sh[4]} : {16'h0, sh[4]};
      else             e.data = wide ? rd32(s) : {16'h0, rd32(s)[15:0]};
      if (op == 2'b01) e.kind = (chan == 4) ? 2 : (chan == 5) ? 3 : 4;
      else             e.kind = 1;
      pend.push_back(e);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      ev_t e;
      int k;
      chk(busy === exp_busy, cur_tag, "busy", busy, exp_busy);
      gcnt++;
      mem_gnt = stall_on ? (gcnt % 3 == 0) : 1'b1;
      mem_rdata = rd32(int'(mem_addr));
      if (mem_req && mem_gnt) begin
        if (expq.size() == 0) begin
          chk(0, cur_tag, "unexpected memory access at", longint'(mem_addr), 0);
        end else begin
          e = expq.pop_front();
          chk(int'(mem_we) == e.kind, cur_tag, "access direction", mem_we, e.kind);
          chk(int'(mem_addr) == e.addr, cur_tag, "memory address R1 R2", mem_addr, e.addr);
          chk(mem_wide == e.wide, "R8", "beat size", mem_wide, e.wide);
          if (mem_we) begin
            chk(mem_wdata == e.data, cur_tag, "write data", mem_wdata, e.data);
            mem[int'(mem_addr)] = mem_wdata[7:0];
            mem[int'(mem_addr) + 1] = mem_wdata[15:8];
            if (mem_wide) begin
              mem[int'(mem_addr) + 2] = mem_wdata[23:16];
              mem[int'(mem_addr) + 3] = mem_wdata[31:24];
            end
          end
        end
      end
      if (buf_vram_we || buf_pal_we || buf_aux_we) begin
        k = buf_vram_we ? 2 : buf_pal_we ? 3 : 4;
        chk(int'(buf_vram_we) + int'(buf_pal_we) + int'(buf_aux_we) == 1, "R5", "strobe count",
            int'(buf_vram_we) + int'(buf_pal_we) + int'(buf_aux_we), 1);
        if (expq.size() == 0) begin
          chk(0, cur_tag, "unexpected buffer strobe", k, 0);
        end else begin
          e = expq.pop_front();
          chk(k == e.kind, "R5", "buffer select", k, e.kind);
          chk(int'(buf_addr) == e.addr, "R5", "buffer address", buf_addr, e.addr);
          chk(buf_wdata == e.data, "R5", "buffer data", buf_wdata, e.data);
        end
      end
      if (arm) begin
        while (pend.size() > 0) expq.push_back(pend.pop_front());
        arm = 0;
      end
      exp_busy = expq.size() != 0;
    end
  end

  task automatic cpu_write(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #2;
    cpu_wr = 1; cpu_idx = a; cpu_wdata = d;
    if (a < 5) sh[a] = d;
    if (a == 3'd7) begin
      if (!exp_busy) plan_job();
      arm = 1;
    end
    @(posedge clk); #2;
    cpu_wr = 0;
  endtask

  task automatic cpu_read(input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(posedge clk); #2;
    cpu_idx = a;
    @(negedge clk);
    chk(cpu_rdata === exp, tag, $sformatf("read index %0d", a), cpu_rdata, exp);
  endtask

  task automatic setup(input logic [15:0] s, input logic [15:0] l, input logic [15:0] d,
                       input logic [15:0] m, input logic [15:0] f);
    cpu_write(3'd0, s);
    cpu_write(3'd1, l);
    cpu_write(3'd2, d);
    cpu_write(3'd3, m);
    cpu_write(3'd4, f);
  endtask

  task automatic drain();
    int t = 0;
    do begin
      @(negedge clk);
      t++;
    end while ((exp_busy || arm || expq.size() != 0) && t < 2000);
    chk(t < 2000, cur_tag, "job did not finish", t, 2000);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && expq.size() == 0, cur_tag, "idle after job", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) sh[i] = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk(busy === 1'b0 && mem_req === 1'b0, "R13", "reset idle", {busy, mem_req}, 0);
    mon_on = 1;

    // R13 reset values and status
    cur_tag = "R13";
    for (int i = 0; i < 5; i++) cpu_read(3'(i), 16'h0, "R13");
    cpu_read(3'd7, 16'h0, "R13");
    cpu_read(3'd5, 16'h0, "R13");

    // R4 R1 R2 R3 word copy, 16 bytes => 8 beats
    cur_tag = "R4";
    setup(16'd2, 16'd2, 16'd10, 16'h0000, 16'h0);
    cpu_read(3'd0, 16'd2, "R13");
    cpu_read(3'd2, 16'd10, "R13");
    cpu_write(3'd7, 16'hBEEF);
    drain();
    chk(rd32(32'h280) == rd32(32'h80), "R4", "copied word", rd32(32'h280), rd32(32'h80));

    // R8 R9 R14 dword copy, palette flag set, stalled grants
    cur_tag = "R9";
    stall_on = 1;
    setup(16'd4, 16'd3, 16'd12, 16'h0088, 16'h0);
    cpu_read(3'd3, 16'h0088, "R9");
    cpu_write(3'd7, 16'h0000);
    drain();

    // R5 buffer copies on channels 4, 5 and 2
    cur_tag = "R5";
    setup(16'd3, 16'd1, 16'd30, 16'h0014, 16'h0);
    cpu_write(3'd7, 16'h1);
    drain();
    setup(16'd3, 16'd2, 16'd31, 16'h001D, 16'h0);
    cpu_write(3'd7, 16'h2);
    drain();
    setup(16'd5, 16'd1, 16'd32, 16'h0012, 16'h0);
    cpu_write(3'd7, 16'h3);
    drain();

    // R6 fill word and dword
    cur_tag = "R6";
    stall_on = 0;
    setup(16'd0, 16'd2, 16'd20, 16'h0110, 16'hA5C3);
    cpu_write(3'd7, 16'h7);
    drain();
    setup(16'd0, 16'd1, 16'd22, 16'h0118, 16'h3C96);
    cpu_write(3'd7, 16'h7);
    drain();
    chk(rd32(32'd22 << 6) == 32'h3C963C96, "R6", "dword fill", rd32(32'd22 << 6), 32'h3C963C96);

    // R7 reserved code
    cur_tag = "R7";
    setup(16'd2, 16'd2, 16'd40, 16'h0100, 16'h0);
    cpu_write(3'd7, 16'h5);
    repeat (12) @(negedge clk);
    chk(busy === 1'b0, "R7", "reserved busy", busy, 0);

    // R12 zero length
    cur_tag = "R12";
    setup(16'd2, 16'd0, 16'd41, 16'h0000, 16'h0);
    cpu_write(3'd7, 16'h5);
    repeat (12) @(negedge clk);
    chk(busy === 1'b0, "R12", "zero length busy", busy, 0);

    // R10 R11 reprogram and kick again during a job
    cur_tag = "R11";
    stall_on = 1;
    setup(16'd6, 16'd2, 16'd44, 16'h0000, 16'h0);
    cpu_write(3'd7, 16'hFFFF);
    cpu_read(3'd7, 16'h1, "R13");
    cpu_write(3'd0, 16'd50);
    cpu_write(3'd2, 16'd60);
    cpu_write(3'd3, 16'h0118);
    cpu_write(3'd7, 16'h1234);
    cpu_read(3'd0, 16'd50, "R10");
    drain();
    cpu_read(3'd7, 16'h0, "R13");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule